// File: doc/BRIEF.md
# Colour Expansion Write Unit

The unit turns one byte written by the CPU into a row of up to eight pixel writes to a frame buffer. Each bit of the data byte stands for one pixel. A 1 bit paints that pixel with a foreground colour. A 0 bit either leaves the pixel alone (transparent mode) or paints it with a background colour (opaque mode). An 8-bit pixel mask can exclude any pixel from the write in both modes.

The unit emits the result as one wide memory write, 16 byte lanes wide, with one enable per byte. It is registered one cycle after the CPU strobe. Pixels are either 8 bits (low byte of each colour) or 16 bits (full colour, two lanes per pixel). The CPU address is scaled so that one byte of CPU address space covers a whole block of frame-buffer memory. When expansion is switched off, the CPU byte passes through to memory unchanged.

Top module: `cexp_write_unit`

## Requirements
- R1: While reset is held and in any cycle without a write, `mem_we` is 0 and `mem_be` is all zeros.
- R2: `mem_we` is high exactly in the cycle after a cycle with `cpu_we` high. The address, data and enables it carries are computed from the inputs sampled in that earlier cycle.
- R3: With `cx_enable` clear, the write passes through. `mem_addr` equals `cpu_addr`, lane 0 carries `cpu_data`, and `mem_be` is 16'h0001, whatever the mode, mask and colour inputs are.
- R4: In transparent mode (`cx_opaque` = 0), a pixel is written only when its data bit is 1, and it receives the foreground colour. A pixel whose data bit is 0 has its lane enables cleared.
- R5: In opaque mode (`cx_opaque` = 1), every unmasked pixel is written. It receives the foreground colour for a 1 bit and the background colour for a 0 bit.
- R6: A pixel whose mask bit is 0 is never enabled, in either mode. Mask bit k gates the pixel selected by data bit k.
- R7: With `cx_pix16` = 1, `mem_addr` = `cpu_addr` << 4. Pixel p occupies lanes 2p (colour bits 7:0) and 2p+1 (colour bits 15:8), and both lanes share the pixel's enable.
- R8: With `cx_pix16` = 0, `mem_addr` = `cpu_addr` << 3 when `cx_scale` = 1, and `mem_addr` = `cpu_addr` when `cx_scale` = 0. Pixel p uses lane p and colour bits 7:0.
- R9: With expansion on and 8-bit pixels, lanes 8 to 15 are never enabled.
- R10: Data bit 7 selects pixel 0 (the lowest address), and data bit 0 selects pixel 7 (the highest address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per byte |
| cpu_addr | input | AW | CPU byte address |
| cpu_data | input | 8 | CPU data byte |
| cx_enable | input | 1 | Colour expansion on |
| cx_opaque | input | 1 | 1: opaque mode, 0: transparent mode |
| cx_pix16 | input | 1 | 16-bit pixels, address shifted by 4 |
| cx_scale | input | 1 | 8-bit pixels: shift address by 3 |
| cx_fg | input | 16 | Foreground colour |
| cx_bg | input | 16 | Background colour |
| cx_mask | input | 8 | Pixel mask, bit k gates data bit k |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW+4 | Memory byte address of lane 0 |
| mem_data | output | 128 | Write data, lane i in bits 8i+7:8i |
| mem_be | output | 16 | Byte-lane enables |

## Verification
The in-module assertions check on every cycle that no lane is enabled without a strobe and that the strobe trails the CPU strobe by one cycle. They also check that a pass-through write enables lane 0 only, that narrow pixels stay out of the upper lanes, that the enable count matches the mask count in opaque mode and never exceeds it otherwise, and that wide writes are 16-byte aligned. Only the bench's sweeps can show the rest. These are the exact bit-to-lane ordering, the colour chosen for each pixel, and the address shift for each mode combination, checked against every data byte under several masks.

// File: rtl/cexp_write_unit.sv
module cexp_write_unit #(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int MAW = AW + 4,
  localparam int NPIX = 8,
  localparam int NLANE = 2 * NPIX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [7:0]         cpu_data,
  input  logic               cx_enable,
  input  logic               cx_opaque,
  input  logic               cx_pix16,
  input  logic               cx_scale,
  input  logic [CW-1:0]      cx_fg,
  input  logic [CW-1:0]      cx_bg,
  input  logic [7:0]         cx_mask,
  output logic               mem_we,
  output logic [MAW-1:0]     mem_addr,
  output logic [8*NLANE-1:0] mem_data,
  output logic [NLANE-1:0]   mem_be
);

  logic [NPIX-1:0]    pen;
  logic [8*NPIX-1:0]  d_narrow;
  logic [8*NLANE-1:0] d_wide;
  logic [NLANE-1:0]   be_wide;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    wire          bit_on = cpu_data[NPIX-1-p];
    wire [CW-1:0] col    = bit_on ? cx_fg : cx_bg;
    assign pen[p] = cx_mask[NPIX-1-p] & (cx_opaque | bit_on);
    assign d_narrow[8*p +: 8]      = col[7:0];
    assign d_wide[16*p +: 16]      = col[15:0];
    assign be_wide[2*p +: 2]       = {2{pen[p]}};
  end

  logic [2:0]         sh_nx;
  logic [MAW-1:0]     addr_nx;
  logic [8*NLANE-1:0] data_nx;
  logic [NLANE-1:0]   be_nx;

  always_comb begin
    sh_nx   = !cx_enable ? 3'd0 : cx_pix16 ? 3'd4 : cx_scale ? 3'd3 : 3'd0;
    addr_nx = MAW'(cpu_addr) << sh_nx;
    if (!cx_enable) begin
      data_nx = {{(8*NLANE-8){1'b0}}, cpu_data};
      be_nx   = NLANE'(1);
    end else if (cx_pix16) begin
      data_nx = d_wide;
      be_nx   = be_wide;
    end else begin
      data_nx = {{(8*NPIX){1'b0}}, d_narrow};
      be_nx   = {{NPIX{1'b0}}, pen};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      mem_be   <= '0;
    end else begin
      mem_we   <= cpu_we;
      mem_addr <= cpu_we ? addr_nx : mem_addr;
      mem_data <= cpu_we ? data_nx : mem_data;
      mem_be   <= cpu_we ? be_nx : '0;
    end
  end

  AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> mem_be == '0); // R1
  AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> mem_we == $past(cpu_we)); // R2
  AST_PASS_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_we && !cx_enable) |-> (mem_be == NLANE'(1) && mem_addr == MAW'($past(cpu_addr)))); // R3
  AST_OPAQUE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_we && cx_enable && cx_opaque && !cx_pix16) |-> $countones(mem_be) == $countones($past(cx_mask))); // R5
  AST_MASK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_we && cx_enable && !cx_pix16) |-> $countones(mem_be) <= $countones($past(cx_mask))); // R6
  AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_we && cx_enable && cx_pix16) |-> mem_addr[3:0] == 4'd0); // R7
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_we && cx_enable && !cx_pix16) |-> mem_be[NLANE-1:NPIX] == '0); // R9

endmodule

// File: tb/test_cexp_write_unit.sv
module test_cexp_write_unit;
  localparam int AW = 16;
  localparam int MAW = AW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_data = '0;
  logic cx_enable = 1'b0, cx_opaque = 1'b0, cx_pix16 = 1'b0, cx_scale = 1'b0;
  logic [15:0] cx_fg = '0, cx_bg = '0;
  logic [7:0] cx_mask = '0;
  logic mem_we;
  logic [MAW-1:0] mem_addr;
  logic [127:0] mem_data;
  logic [15:0] mem_be;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cexp_write_unit #(.AW(AW)) i_cexp_write_unit (
    .clk, .rst_n, .cpu_we, .cpu_addr, .cpu_data, .cx_enable, .cx_opaque,
    .cx_pix16, .cx_scale, .cx_fg, .cx_bg, .cx_mask,
    .mem_we, .mem_addr, .mem_data, .mem_be);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic write_and_check();
    logic [MAW-1:0] e_addr;
    logic [127:0]   e_data;
    logic [15:0]    e_be;
    logic [127:0]   lane_m;
    string tag;
    e_data = '0; e_be = '0;
    if (!cx_enable) begin
      tag = "R3"; e_addr = MAW'(cpu_addr); e_data[7:0] = cpu_data; e_be = 16'h0001;
    end else begin
      tag = cx_pix16 ? "R7" : cx_opaque ? "R5" : "R4";
      e_addr = cx_pix16 ? MAW'(cpu_addr) * 16 : cx_scale ? MAW'(cpu_addr) * 8 : MAW'(cpu_addr);
      for (int p = 0; p < 8; p++) begin
        bit b = cpu_data[7-p];
        bit en = cx_mask[7-p] && (cx_opaque || b);
        logic [15:0] c = b ? cx_fg : cx_bg;
        if (cx_pix16) begin
          e_data[16*p +: 16] = c; e_be[2*p] = en; e_be[2*p+1] = en;
        end else begin
          e_data[8*p +: 8] = c[7:0]; e_be[p] = en;
        end
      end
    end
    lane_m = '0;
    for (int i = 0; i < 16; i++) if (e_be[i]) lane_m[8*i +: 8] = 8'hFF;
    cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    check(mem_we === 1'b1, "R2", "mem_we after strobe", 128'(mem_we), 128'(1));
    check(mem_be === e_be, tag, "mem_be (R6 R8 R9 R10)", 128'(mem_be), 128'(e_be));
    check(mem_addr === e_addr, cx_pix16 ? "R7" : "R8", "mem_addr", 128'(mem_addr), 128'(e_addr));
    check((mem_data & lane_m) === (e_data & lane_m), tag, "mem_data lanes", mem_data & lane_m, e_data & lane_m);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] masks [4];
    masks[0] = 8'hFF; masks[1] = 8'h00; masks[2] = 8'hA5; masks[3] = 8'h3C;
    repeat (3) @(negedge clk);
    check(mem_we === 1'b0 && mem_be === 16'h0, "R1", "reset state", 128'({mem_we, mem_be}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_we === 1'b0 && mem_be === 16'h0, "R1", "idle after reset", 128'({mem_we, mem_be}), 128'(0));

    cx_enable = 1'b1; cx_mask = 8'hFF; cx_fg = 16'h00C7; cpu_data = 8'h80; cpu_addr = 16'h0010;
    cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    check(mem_be === 16'h0001, "R10", "bit 7 to lowest pixel", 128'(mem_be), 128'(1));
    cpu_data = 8'h01;
    cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    check(mem_be === 16'h0080, "R10", "bit 0 to highest pixel", 128'(mem_be), 128'(16'h0080));
    @(negedge clk);
    check(mem_we === 1'b0 && mem_be === 16'h0, "R1", "idle cycle", 128'({mem_we, mem_be}), 128'(0));

    for (int m = 0; m < 16; m++) begin
      cx_enable = m[0]; cx_opaque = m[1]; cx_pix16 = m[2]; cx_scale = m[3];
      cx_fg = 16'hC3A5 ^ 16'(m * 16'h0111);
      cx_bg = 16'h5A3C ^ 16'(m * 16'h1010);
      for (int mi = 0; mi < 4; mi++) begin
        cx_mask = masks[mi];
        for (int d = 0; d < 256; d++) begin
          cpu_data = 8'(d);
          cpu_addr = 16'(d * 37 + mi * 4099 + m * 511);
          write_and_check();
        end
      end
    end
    @(negedge clk);
    check(mem_we === 1'b0 && mem_be === 16'h0, "R1", "idle at end", 128'({mem_we, mem_be}), 128'(0));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule